// File: doc/BRIEF.md
# Serialized Interrupt Slot Router

This block places two level-sensitive interrupt requests from one function, called A and B, onto the four PCI interrupt positions (INTA, INTB, INTC, INTD) that a serialized interrupt frame carries. A two-bit rotation field picks where the pair lands. A lands on slot `step`, and B lands on the slot after it, wrapping from INTD back to INTA. Setting the field differently in each of several functions spreads their interrupts evenly over the four positions.

A merge option ORs A and B into one request. That request is then signalled in A's position only, and the rotation still applies to it. The merge acts only while serialized mode is enabled. With serialized mode off, every slot output is held inactive. The slot vector is registered and feeds a frame serializer. The serializer is outside this block.

Top module: `irq_slot_router`

## Requirements
- R1: While `rst_n` is low, and at the first clock edge after it goes low, `slot_req` is 4'b0000.
- R2: With `ser_en`=1, `tie`=0 and `step`=2'b00, `slot_req[0]` (INTA) follows `req_a` and `slot_req[1]` (INTB) follows `req_b`. `slot_req[3:2]` are 0.
- R3: With `ser_en`=1, `tie`=0 and `step`=2'b01, `slot_req[1]` follows `req_a` and `slot_req[2]` follows `req_b`. Bits 0 and 3 are 0.
- R4: With `ser_en`=1, `tie`=0 and `step`=2'b10, `slot_req[2]` follows `req_a` and `slot_req[3]` follows `req_b`. Bits 0 and 1 are 0.
- R5: With `ser_en`=1, `tie`=0 and `step`=2'b11, `slot_req[3]` follows `req_a` and `req_b` wraps to `slot_req[0]`. Bits 1 and 2 are 0.
- R6: With `ser_en`=1 and `tie`=1, the slot numbered `step` carries `req_a | req_b` and every other slot is 0. At most one bit of `slot_req` is set.
- R7: With `ser_en`=0, `slot_req` is 4'b0000 whatever the values of `tie`, `step` and the requests.
- R8: `slot_req` is registered. It reflects the inputs sampled at the previous rising edge of `clk`, so a change on any input reaches `slot_req` exactly one clock later and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_a | input | 1 | Level interrupt request A |
| req_b | input | 1 | Level interrupt request B |
| step | input | 2 | Rotation: slot index that A lands on |
| tie | input | 1 | Merge A and B into A's slot |
| ser_en | input | 1 | Serialized interrupt mode enabled |
| slot_req | output | 4 | Slot requests, bit 0 = INTA through bit 3 = INTD |

## Verification
The only internal state is the output register, so any wrong decode of the rotation or of the merge is visible on `slot_req` one edge after the inputs are applied. A wrong slot index shows as a bit set in the wrong position. A bad wrap shows as B missing from INTA under step 2'b11. A broken merge shows as two bits set, or as a request lost when only B is active. Every combination of the two requests, the four rotations, the merge bit and the enable is driven. Each result is compared at the first edge after it is applied, and the output is also checked just before that edge to confirm it did not change early.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  typedef struct packed {
    logic a;
    logic b;
  } req_pair_t;
endpackage

// File: rtl/irq_pair_merge.sv
module irq_pair_merge
  import irq_router_pkg::*;
(
  input  req_pair_t raw,
  input  logic      merge_en,
  output req_pair_t merged
);
  always_comb begin
    if (merge_en) begin
      merged.a = raw.a | raw.b;
      merged.b = 1'b0;
    end else begin
      merged = raw;
    end
  end
endmodule

// File: rtl/irq_slot_rotate.sv
module irq_slot_rotate
  import irq_router_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int STEP_W    = $clog2(NUM_SLOTS)
) (
  input  req_pair_t             pair,
  input  logic [STEP_W-1:0]     rot,
  output logic [NUM_SLOTS-1:0]  slots
);
  // B lands one slot after A; the adder wraps modulo 2**STEP_W.
  logic [STEP_W-1:0] b_pos;
  assign b_pos = rot + STEP_W'(1);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign slots[i] = (pair.a && (rot   == STEP_W'(i)))
                    | (pair.b && (b_pos == STEP_W'(i)));
  end
endmodule

// File: rtl/irq_slot_reg.sv
module irq_slot_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (enable) q <= d;
    else             q <= '0;
  end
endmodule

// File: rtl/irq_slot_router.sv
module irq_slot_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int STEP_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_a,
  input  logic                 req_b,
  input  logic [STEP_W-1:0]    step,
  input  logic                 tie,
  input  logic                 ser_en,
  output logic [NUM_SLOTS-1:0] slot_req
);
  req_pair_t            raw_pair;
  req_pair_t            merged_pair;
  logic [NUM_SLOTS-1:0] rotated;
  logic                 merge_live;

  assign raw_pair.a = req_a;
  assign raw_pair.b = req_b;
  // The merge is honoured only once serialized mode is selected.
  assign merge_live = tie & ser_en;

  irq_pair_merge u_merge (
    .raw      (raw_pair),
    .merge_en (merge_live),
    .merged   (merged_pair)
  );

  irq_slot_rotate #(.NUM_SLOTS(NUM_SLOTS), .STEP_W(STEP_W)) u_rotate (
    .pair  (merged_pair),
    .rot   (step),
    .slots (rotated)
  );

  irq_slot_reg #(.WIDTH(NUM_SLOTS)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (ser_en),
    .d      (rotated),
    .q      (slot_req)
  );
endmodule

// File: rtl/irq_slot_router_chk.sv
module irq_slot_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_a,
  input logic       req_b,
  input logic [1:0] step,
  input logic       tie,
  input logic       ser_en,
  input logic [3:0] slot_req
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> slot_req == 4'b0000);

  assert_step0_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(ser_en && !tie && step == 2'd0) |->
      slot_req == {2'b00, $past(req_b), $past(req_a)});

  assert_step1_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(ser_en && !tie && step == 2'd1) |->
      slot_req == {1'b0, $past(req_b), $past(req_a), 1'b0});

  assert_step2_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(ser_en && !tie && step == 2'd2) |->
      slot_req == {$past(req_b), $past(req_a), 2'b00});

  assert_step3_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(ser_en && !tie && step == 2'd3) |->
      slot_req == {$past(req_a), 2'b00, $past(req_b)});

  assert_tie_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(ser_en && tie) |->
      $countones(slot_req) == ($past(req_a | req_b) ? 1 : 0));

  assert_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(ser_en) |-> slot_req == 4'b0000);

  assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $stable({req_a, req_b, step, tie, ser_en}) |=> $stable(slot_req));
endmodule

bind irq_slot_router irq_slot_router_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_a    (req_a),
  .req_b    (req_b),
  .step     (step),
  .tie      (tie),
  .ser_en   (ser_en),
  .slot_req (slot_req)
);

// File: tb/tb_irq_slot_router.sv
module tb_irq_slot_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_a = 1'b0;
  logic       req_b = 1'b0;
  logic [1:0] step = 2'd0;
  logic       tie = 1'b0;
  logic       ser_en = 1'b0;
  logic [3:0] slot_req;

  int compared = 0;
  int mismatched = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic [3:0] last_exp = 4'b0000;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  irq_slot_router dut (
    .clk(clk), .rst_n(rst_n), .req_a(req_a), .req_b(req_b),
    .step(step), .tie(tie), .ser_en(ser_en), .slot_req(slot_req)
  );

  function automatic logic [3:0] model(input logic a, input logic b,
                                       input logic [1:0] s, input logic t,
                                       input logic en);
    logic pa, pb;
    if (!en) return 4'b0000;
    pa = t ? (a | b) : a;
    pb = t ? 1'b0 : b;
    case (s)
      2'd0: return {1'b0, 1'b0, pb, pa};
      2'd1: return {1'b0, pb, pa, 1'b0};
      2'd2: return {pb, pa, 1'b0, 1'b0};
      default: return {pa, 1'b0, 1'b0, pb};
    endcase
  endfunction

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: slot_req=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic b, input logic [1:0] s,
                       input logic t, input logic en);
    logic [3:0] e;
    string tg;
    @(negedge clk);
    req_a = a; req_b = b; step = s; tie = t; ser_en = en;
    e = model(a, b, s, t, en);
    if (!en)    tg = "R7";
    else if (t) tg = "R6";
    else        tg = $sformatf("R%0d", 2 + s);
    exp_q.push_back(e);
    tag_q.push_back(tg);
    #1;
    check(slot_req, last_exp, "R8 (no early change)");
    last_exp = e;
  endtask

  // Monitor: compare one edge after each drive.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      check(slot_req, e, {tg, " / R8"});
    end
  end

  initial begin
    #400000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: expected=done actual=hung");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(slot_req, 4'b0000, "R1");
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R2-R7: every request, rotation, merge and enable combination.
    for (int en = 1; en >= 0; en--)
      for (int t = 0; t < 2; t++)
        for (int s = 0; s < 4; s++)
          for (int v = 0; v < 4; v++)
            drive(v[0], v[1], s[1:0], t[0], en[0]);
    // R5 wrap and R6 B-only merge, then back-to-back changes for R8.
    drive(1'b0, 1'b1, 2'd3, 1'b0, 1'b1);
    drive(1'b0, 1'b1, 2'd2, 1'b1, 1'b1);
    drive(1'b1, 1'b1, 2'd1, 1'b0, 1'b1);
    drive(1'b1, 1'b1, 2'd1, 1'b1, 1'b0);
    drive(1'b1, 1'b0, 2'd0, 1'b0, 1'b1);
    repeat (3) @(posedge clk);
    // R1: reset clears a live output.
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk) #1 check(slot_req, 4'b0000, "R1");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule